// File: doc/BRIEF.md
# Packed Horizontal Minimum Unit

This datapath block searches a 128-bit operand for its smallest word. The operand holds eight unsigned 16-bit lanes, and lane 0 is the least significant word. The block returns the smallest value together with the number of the lane that held it, packed into fixed bit positions of a destination word as wide as the widest vector register. All other bits of the low 128 are zero.

Two encoding modes control the destination bits above 127:

- In legacy mode those bits pass through unchanged from the prior destination contents supplied on an input.
- In vector-extended mode those bits are cleared.

In vector-extended mode two decode fields are also checked. A malformed encoding returns an all-zero word with the illegal flag set, in place of a result.

The search is a tree of pairwise compare/select cells. A bit mask places an optional register after any level of the tree. The input valid, the mode, the illegal flag and the upper destination bits travel through the same registers as the data. The block has no status flags.

Top module: `hmin_unit`

## Requirements
- R1: `out_res[15:0]` holds the unsigned minimum of the eight 16-bit lanes of `in_op`. Lane k occupies `in_op[16k+15:16k]`.
- R2: `out_res[18:16]` holds the number (0 to 7) of the lane that supplied the minimum.
- R3: When several lanes share the minimum value, the lowest-numbered of them is reported.
- R4: `out_res[127:19]` is always zero.
- R5: For a legal operation with `in_vext`=0 (legacy), `out_res[VLEN_MAX-1:128]` equals `in_upper` as sampled with the operand.
- R6: With `in_vext`=1 (vector-extended), `out_res[VLEN_MAX-1:128]` is zero.
- R7: With `in_vext`=1, if `in_vlen`=1 or `in_xreg`≠4'b1111, the result has `out_valid`=1, `out_illegal`=1 and `out_res` all zero.
- R8: With `in_vext`=0, `in_vlen` and `in_xreg` have no effect: `out_illegal` stays 0 and the result is computed normally.
- R9: After reset `out_valid` is 0. A result appears exactly as many cycles after its operand as `PIPE_MASK` has set bits among the tree levels (2 for the default mask 5). Cycles with `in_valid`=0 give `out_valid`=0.
- R10: When every lane is 16'hFFFF, the result is value 16'hFFFF with lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand qualifier |
| in_op | input | OP_W (128) | Eight packed unsigned 16-bit lanes |
| in_vext | input | 1 | 0 = legacy mode, 1 = vector-extended mode |
| in_vlen | input | 1 | Vector-length decode field; must be 0 in vector-extended mode |
| in_xreg | input | XREG_W (4) | Extra-register decode field; must be all ones in vector-extended mode |
| in_upper | input | VLEN_MAX-OP_W (384) | Prior destination bits above 127 |
| out_valid | output | 1 | Result qualifier |
| out_illegal | output | 1 | Malformed encoding flag |
| out_res | output | VLEN_MAX (512) | Packed result word |

## Verification
Two effects can land in the same result word in the same cycle: the tie rule among equal lanes, and the mode-dependent treatment of the bits above 127. The illegal-encoding override can also land in that cycle and must mask both.

The bench provokes all three together. Random operands draw lane values from a narrow range so that equal minima are common, and the mode, both decode fields and the prior upper contents change freely from one cycle to the next. Back-to-back operands with idle gaps between them exercise the pipeline overlap.

Each cycle the full 512-bit word, the valid and the illegal flag are compared against a sequential-scan model delayed by the pipeline latency.

// File: rtl/hmin_pkg.sv
package hmin_pkg;

   typedef enum logic {
      ENC_LEGACY = 1'b0,
      ENC_VEXT   = 1'b1
   } enc_mode_e;

   // number of registered tree levels selected by a level mask
   function automatic int unsigned pipe_latency(int unsigned mask, int unsigned lvls);
      int unsigned n;
      n = 0;
      for (int unsigned i = 0; i < lvls; i++) begin
         if (((mask >> i) & 1) != 0) n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/hmin_legal.sv
module hmin_legal #(
   parameter int unsigned XREG_W = 4
) (
   input  logic              mode,
   input  logic              vlen_bit,
   input  logic [XREG_W-1:0] xreg,
   output logic              illegal
);
   import hmin_pkg::*;

   // only the vector-extended form carries constraints on the two fields
   always_comb begin
      illegal = 1'b0;
      if (enc_mode_e'(mode) == ENC_VEXT) begin
         illegal = vlen_bit || (xreg != {XREG_W{1'b1}});
      end
   end
endmodule

// File: rtl/hmin_pair.sv
module hmin_pair #(
   parameter int unsigned LANE_W = 16,
   parameter int unsigned IDX_W  = 3,
   parameter bit          REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LANE_W-1:0] a_val,
   input  logic [IDX_W-1:0]  a_idx,
   input  logic [LANE_W-1:0] b_val,
   input  logic [IDX_W-1:0]  b_idx,
   output logic [LANE_W-1:0] y_val,
   output logic [IDX_W-1:0]  y_idx
);
   logic              take_b;
   logic [LANE_W-1:0] sel_val;
   logic [IDX_W-1:0]  sel_idx;

   // input a always comes from the lower lanes; b wins only when strictly smaller
   assign take_b  = b_val < a_val;
   assign sel_val = take_b ? b_val : a_val;
   assign sel_idx = take_b ? b_idx : a_idx;

   generate
      if (REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               y_val <= '0;
               y_idx <= '0;
            end else begin
               y_val <= sel_val;
               y_idx <= sel_idx;
            end
         end
      end else begin : g_comb
         assign y_val = sel_val;
         assign y_idx = sel_idx;
      end
   endgenerate
endmodule

// File: rtl/hmin_delay.sv
module hmin_delay #(
   parameter int unsigned W   = 8,
   parameter bit          REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_comb
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/hmin_unit.sv
module hmin_unit #(
   parameter int unsigned OP_W      = 128,
   parameter int unsigned LANE_W    = 16,
   parameter int unsigned VLEN_MAX  = 512,
   parameter int unsigned XREG_W    = 4,
   parameter int unsigned PIPE_MASK = 5,
   localparam int unsigned UPW_P    = (VLEN_MAX > OP_W) ? (VLEN_MAX - OP_W) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [OP_W-1:0]     in_op,
   input  logic                in_vext,
   input  logic                in_vlen,
   input  logic [XREG_W-1:0]   in_xreg,
   input  logic [UPW_P-1:0]    in_upper,
   output logic                out_valid,
   output logic                out_illegal,
   output logic [VLEN_MAX-1:0] out_res
);
   localparam int unsigned LANES = OP_W / LANE_W;
   localparam int unsigned LVLS  = $clog2(LANES);
   localparam int unsigned IDX_W = LVLS;
   localparam int unsigned UPW   = VLEN_MAX - OP_W;
   localparam int unsigned SB_W  = 3 + UPW_P;

   generate
      if (LANES * LANE_W != OP_W || (1 << LVLS) != LANES || LANES < 2) begin : g_bad_lanes
         $error("hmin_unit: OP_W must split into a power-of-two count of lanes");
      end
      if (VLEN_MAX != 128 && VLEN_MAX != 256 && VLEN_MAX != 512) begin : g_bad_vlen
         $error("hmin_unit: VLEN_MAX must be 128, 256 or 512");
      end
      if (OP_W != 128 || LANE_W + IDX_W > OP_W) begin : g_bad_fields
         $error("hmin_unit: operand must be 128 bits wide with room for value and index");
      end
   endgenerate

   logic [LANE_W-1:0] lv_val [LVLS+1][LANES];
   logic [IDX_W-1:0]  lv_idx [LVLS+1][LANES];
   logic [SB_W-1:0]   sb     [LVLS+1];
   logic              ill_in;

   hmin_legal #(.XREG_W(XREG_W)) u_legal (
      .mode     (in_vext),
      .vlen_bit (in_vlen),
      .xreg     (in_xreg),
      .illegal  (ill_in)
   );

   // sideband word: valid, illegal, mode, prior upper contents
   assign sb[0] = {in_valid, ill_in, in_vext, in_upper};

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_leaf
         assign lv_val[0][k] = in_op[k*LANE_W +: LANE_W];
         assign lv_idx[0][k] = IDX_W'(k);
      end

      for (genvar l = 0; l < LVLS; l++) begin : g_lvl
         localparam bit REG_L = ((PIPE_MASK >> l) & 1) != 0;
         for (genvar k = 0; k < (LANES >> (l + 1)); k++) begin : g_cell
            hmin_pair #(.LANE_W(LANE_W), .IDX_W(IDX_W), .REG(REG_L)) u_pair (
               .clk   (clk),
               .rst_n (rst_n),
               .a_val (lv_val[l][2*k]),
               .a_idx (lv_idx[l][2*k]),
               .b_val (lv_val[l][2*k+1]),
               .b_idx (lv_idx[l][2*k+1]),
               .y_val (lv_val[l+1][k]),
               .y_idx (lv_idx[l+1][k])
            );
         end
         hmin_delay #(.W(SB_W), .REG(REG_L)) u_sb (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (sb[l]),
            .q     (sb[l+1])
         );
      end
   endgenerate

   logic              f_valid;
   logic              f_ill;
   logic              f_vext;
   logic [UPW_P-1:0]  f_upper;
   logic [LANE_W-1:0] f_val;
   logic [IDX_W-1:0]  f_idx;

   assign {f_valid, f_ill, f_vext, f_upper} = sb[LVLS];
   assign f_val = lv_val[LVLS][0];
   assign f_idx = lv_idx[LVLS][0];

   logic [VLEN_MAX-1:0] upper_full;
   generate
      if (UPW > 0) begin : g_upper
         assign upper_full = {f_upper, {OP_W{1'b0}}};
      end else begin : g_no_upper
         assign upper_full = '0;
      end
   endgenerate

   always_comb begin
      out_valid   = f_valid;
      out_illegal = f_valid && f_ill;
      out_res     = '0;
      if (f_valid && !f_ill) begin
         out_res[LANE_W-1:0]       = f_val;
         out_res[LANE_W +: IDX_W]  = f_idx;
         if (hmin_pkg::enc_mode_e'(f_vext) == hmin_pkg::ENC_LEGACY) begin
            out_res = out_res | upper_full;
         end
      end
   end
endmodule

// File: rtl/hmin_unit_chk.sv
module hmin_unit_chk #(
   parameter int unsigned OP_W      = 128,
   parameter int unsigned LANE_W    = 16,
   parameter int unsigned VLEN_MAX  = 512,
   parameter int unsigned XREG_W    = 4,
   parameter int unsigned PIPE_MASK = 5,
   localparam int unsigned UPW_P    = (VLEN_MAX > OP_W) ? (VLEN_MAX - OP_W) : 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_vext,
   input logic                in_vlen,
   input logic [XREG_W-1:0]   in_xreg,
   input logic [UPW_P-1:0]    in_upper,
   input logic                out_valid,
   input logic                out_illegal,
   input logic [VLEN_MAX-1:0] out_res
);
   localparam int unsigned LANES = OP_W / LANE_W;
   localparam int unsigned LVLS  = $clog2(LANES);
   localparam int unsigned IDX_W = LVLS;
   localparam int unsigned LAT   = hmin_pkg::pipe_latency(PIPE_MASK, LVLS);
   localparam int unsigned SB_W  = 3 + UPW_P;

   // expected sideband, aged by the pipeline latency
   logic [SB_W-1:0] age [LAT+1];
   assign age[0] = {in_valid,
                    in_vext && (in_vlen || (in_xreg != {XREG_W{1'b1}})),
                    in_vext, in_upper};

   generate
      for (genvar i = 1; i <= LAT; i++) begin : g_age
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) age[i] <= '0;
            else        age[i] <= age[i-1];
         end
      end
   endgenerate

   logic             e_valid;
   logic             e_ill;
   logic             e_vext;
   logic [UPW_P-1:0] e_upper;
   assign {e_valid, e_ill, e_vext, e_upper} = age[LAT];

   p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      e_valid |-> out_valid);
   p_idle_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !e_valid |-> !out_valid);
   p_ill_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_illegal == e_ill));
   p_ill_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_illegal) |-> (out_res == '0));
   p_mid_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_res[OP_W-1:LANE_W+IDX_W] == '0));

   generate
      if (VLEN_MAX > OP_W) begin : g_up_chk
         p_keep_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_illegal && !e_vext) |-> (out_res[VLEN_MAX-1:OP_W] == e_upper));
         p_clear_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && e_vext) |-> (out_res[VLEN_MAX-1:OP_W] == '0));
      end
   endgenerate
endmodule

bind hmin_unit hmin_unit_chk #(
   .OP_W      (OP_W),
   .LANE_W    (LANE_W),
   .VLEN_MAX  (VLEN_MAX),
   .XREG_W    (XREG_W),
   .PIPE_MASK (PIPE_MASK)
) u_hmin_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_vext     (in_vext),
   .in_vlen     (in_vlen),
   .in_xreg     (in_xreg),
   .in_upper    (in_upper),
   .out_valid   (out_valid),
   .out_illegal (out_illegal),
   .out_res     (out_res)
);

// File: tb/test_hmin_unit.sv
`timescale 1ns/1ps
module test_hmin_unit;
   localparam int OP_W = 128, LANE_W = 16, VLEN_MAX = 512, XREG_W = 4;
   localparam int PIPE_MASK = 5;
   localparam int LAT = 2;            // two set bits in the mask
   localparam int UPW = VLEN_MAX - OP_W;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                in_valid = 1'b0;
   logic [OP_W-1:0]     in_op = '0;
   logic                in_vext = 1'b0;
   logic                in_vlen = 1'b0;
   logic [XREG_W-1:0]   in_xreg = '1;
   logic [UPW-1:0]      in_upper = '0;
   logic                out_valid;
   logic                out_illegal;
   logic [VLEN_MAX-1:0] out_res;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   hmin_unit #(.OP_W(OP_W), .LANE_W(LANE_W), .VLEN_MAX(VLEN_MAX),
               .XREG_W(XREG_W), .PIPE_MASK(PIPE_MASK)) i_hmin_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_vext(in_vext), .in_vlen(in_vlen), .in_xreg(in_xreg), .in_upper(in_upper),
      .out_valid(out_valid), .out_illegal(out_illegal), .out_res(out_res));

   typedef struct {
      logic                v;
      logic                ill;
      logic [VLEN_MAX-1:0] res;
      string               tag;
   } exp_t;
   exp_t pend[$];

   // sequential scan model
   function automatic exp_t model(logic v, logic [OP_W-1:0] op, logic vext, logic vlen,
                                  logic [XREG_W-1:0] xreg, logic [UPW-1:0] up, string tag);
      exp_t e;
      int mv, mi;
      e.v = v; e.tag = tag; e.res = '0;
      e.ill = v && vext && (vlen || xreg != 4'b1111);
      if (v && !e.ill) begin
         mv = int'(op[15:0]); mi = 0;
         for (int i = 1; i < 8; i++) begin
            if (int'(op[16*i +: 16]) < mv) begin
               mv = int'(op[16*i +: 16]); mi = i;
            end
         end
         e.res[15:0]  = 16'(mv);
         e.res[18:16] = 3'(mi);
         if (!vext) e.res[VLEN_MAX-1:OP_W] = up;
      end
      return e;
   endfunction

   task automatic step(logic v, logic [OP_W-1:0] op, logic vext, logic vlen,
                       logic [XREG_W-1:0] xreg, logic [UPW-1:0] up, string tag);
      exp_t e;
      @(negedge clk);
      if (pend.size() == LAT) begin
         e = pend.pop_front();
         checks++;
         if (out_valid !== e.v || (e.v && (out_illegal !== e.ill || out_res !== e.res))) begin
            fails++;
            $display("FAIL %s: actual v=%b ill=%b res=%h expected v=%b ill=%b res=%h",
                     e.tag, out_valid, out_illegal, out_res, e.v, e.ill, e.res);
         end
      end
      in_valid = v; in_op = op; in_vext = vext; in_vlen = vlen; in_xreg = xreg; in_upper = up;
      pend.push_back(model(v, op, vext, vlen, xreg, up, tag));
   endtask

   function automatic logic [UPW-1:0] rnd_up();
      logic [UPW-1:0] u;
      for (int i = 0; i < UPW/32; i++) u[32*i +: 32] = $urandom;
      return u;
   endfunction

   function automatic logic [OP_W-1:0] splat(logic [15:0] w);
      return {8{w}};
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R9: watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [OP_W-1:0] op;
      repeat (3) @(negedge clk);
      // R9: reset state
      checks++;
      if (out_valid !== 1'b0 || out_res !== '0) begin
         fails++;
         $display("FAIL R9: reset actual v=%b res=%h expected v=0 res=0", out_valid, out_res);
      end
      rst_n = 1'b1;

      // R10: all lanes at full scale
      step(1, splat(16'hFFFF), 0, 0, 4'hF, rnd_up(), "R10");
      // R3: all lanes equal
      step(1, splat(16'h1234), 1, 0, 4'hF, rnd_up(), "R3");
      // R1 R2: minimum in each lane position
      for (int k = 0; k < 8; k++) begin
         op = splat(16'h8000);
         op[16*k +: 16] = 16'h0007;
         step(1, op, k[0], 0, 4'hF, rnd_up(), "R2");
      end
      // R1: unsigned compare, a top-bit-set lane must not win
      op = splat(16'h7000); op[16*3 +: 16] = 16'hF000; op[16*6 +: 16] = 16'h0100;
      step(1, op, 0, 0, 4'hF, rnd_up(), "R1");
      // R3: duplicate minima in lanes 2 and 5
      op = splat(16'h4444); op[16*2 +: 16] = 16'h0010; op[16*5 +: 16] = 16'h0010;
      step(1, op, 0, 0, 4'hF, rnd_up(), "R3");
      op[16*7 +: 16] = 16'h0010; op[16*2 +: 16] = 16'h0011;
      step(1, op, 1, 0, 4'hF, rnd_up(), "R3");
      // R8: legacy mode ignores bad field values; R5 upper kept
      step(1, op, 0, 1, 4'h0, rnd_up(), "R8");
      step(1, op, 0, 0, 4'hF, rnd_up(), "R5");
      // R6: vector-extended legal clears upper bits
      step(1, op, 1, 0, 4'hF, '1, "R6");
      // R7: illegal encodings
      step(1, op, 1, 1, 4'hF, rnd_up(), "R7");
      step(1, op, 1, 0, 4'hE, rnd_up(), "R7");
      step(1, op, 1, 1, 4'h3, rnd_up(), "R7");
      // R9: idle gaps
      step(0, op, 0, 0, 4'hF, rnd_up(), "R9");
      step(1, op, 0, 0, 4'hF, rnd_up(), "R9");
      step(0, op, 1, 1, 4'h0, rnd_up(), "R9");
      // R4 R1 R3 R5 R6 R7: random, narrowed lanes for frequent ties
      for (int n = 0; n < 600; n++) begin
         for (int i = 0; i < 8; i++)
            op[16*i +: 16] = (n % 3 == 0) ? 16'($urandom_range(0, 3)) : 16'($urandom);
         step(($urandom_range(0, 5) != 0), op, 1'($urandom),
              ($urandom_range(0, 7) == 0),
              ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'hF,
              rnd_up(), "R4");
      end
      for (int n = 0; n < LAT + 2; n++) step(0, '0, 0, 0, 4'hF, '0, "R9");
      done = 1'b1;
      summary();
      $finish;
   end
endmodule